// File: doc/BRIEF.md
# Daylight Saving Time Switch Detector

This block sits beside a real-time clock's calendar counters and decides when the clock must jump for daylight saving time. It holds two rules, one for entering summer time (forward) and one for leaving it (reverse). Each rule names a month, an hour, and a day. The day is given either as a day of the week or as a date of the month, and a per-rule priority bit picks which one applies. A global enable bit, kept in the forward month register, switches the whole function on or off.

When the live calendar reaches a rule's hour with minutes and seconds at zero, the block raises a one-cycle strobe. The forward strobe tells the time counters to advance one hour, and the reverse strobe tells them to retard one hour. An in-summer-time flag is set by a forward event and cleared by a reverse event. A reverse event needs the flag to be set, so the hour that repeats after falling back cannot trigger a second reverse. The calendar counters and the host bus are outside this block. Rules are loaded through a simple byte write port.

Top module: `dst_switch`

## Requirements
- R1: After reset, both strobes and the in-summer-time flag are 0, and the rules hold their defaults. Forward: disabled, month 4, day-of-week priority 0, day of week 0 (Sunday), date 1, hour 2. Reverse: month 10, priority 0, day of week 0, date 1, hour 2.
- R2: Rule registers are written one byte at a time at addresses RULE_BASE (default 15h) to RULE_BASE+7.
  - Forward rule: month at +0 (bit 7 enable, bits 3:0 month 1..12), day of week at +1 (bit 7 priority, bits 2:0 day 0..6), date at +2 (bits 4:0), hour at +3 (bits 4:0, 0..23).
  - Reverse rule: the same layout at +4..+7, and bit 7 of +4 is not stored.
  - Writes to other addresses change nothing.
- R3: While the enable bit is 0, neither strobe fires and the flag keeps its value.
- R4: A rule matches when month and hour are equal and one day field is equal. With priority 1 the day field is the day of week and the date is ignored. With priority 0 the day field is the date and the day of week is ignored.
- R5: On the first clock edge at which the forward rule matches, fwd_strobe is 1 for the following cycle and the flag becomes 1.
- R6: A rule that stays matched gives no further strobe. A new strobe needs the match to be lost and then regained.
- R7: A reverse match fires rev_strobe for one cycle and clears the flag, but only while the flag is 1. The repeated hour after falling back does not fire again.
- R8: If both rules start matching on the same edge, only the forward strobe fires.
- R9: A nonzero minute or second value prevents any match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Rule register write strobe |
| cfg_addr | input | 8 | Rule register address |
| cfg_wdata | input | 8 | Rule register write data |
| cal_month | input | 4 | Calendar month, 1..12 |
| cal_dow | input | 3 | Calendar day of week, 0..6 |
| cal_date | input | 5 | Calendar date, 1..31 |
| cal_hour | input | 5 | Calendar hour, 0..23 |
| cal_min | input | 6 | Calendar minutes |
| cal_sec | input | 6 | Calendar seconds |
| fwd_strobe | output | 1 | One-cycle advance-one-hour event |
| rev_strobe | output | 1 | One-cycle retard-one-hour event |
| in_dst | output | 1 | Summer time in effect |

## Verification
Matching is combinational, and each strobe comes from a single register. A strobe is therefore due in the cycle right after the first rising edge that sees a match. The flag changes on that same edge. A rule write also settles in one edge, so the new rule governs the match at the following edge. The bench changes calendar and write inputs only at falling edges, lets exactly one rising edge pass, and samples at the next falling edge. In this way every strobe and flag value is read in the one cycle it is due.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam int REG_W     = 8;
  localparam int MON_W     = 4;
  localparam int DOW_W     = 3;
  localparam int DATE_W    = 5;
  localparam int HOUR_W    = 5;
  localparam int MIN_W     = 6;
  localparam int SEC_W     = 6;
  localparam int RULE_REGS = 4;
  localparam int N_RULES   = 2;
  localparam int N_REGS    = RULE_REGS * N_RULES;
  localparam int SEL_W     = $clog2(N_REGS);
  localparam int EN_BIT    = REG_W - 1;
  localparam int PRIO_BIT  = REG_W - 1;

  typedef struct packed {
    logic [MON_W-1:0]  mon;
    logic              dow_prio;
    logic [DOW_W-1:0]  dow;
    logic [DATE_W-1:0] date;
    logic [HOUR_W-1:0] hour;
  } rule_t;

  typedef struct packed {
    logic [MON_W-1:0]  mon;
    logic [DOW_W-1:0]  dow;
    logic [DATE_W-1:0] date;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_t;

  // Reset value of each rule register, by index within the bank.
  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx % RULE_REGS)
      0:       reg_default = (idx < RULE_REGS) ? 8'h04 : 8'h0A;
      1:       reg_default = 8'h00;
      2:       reg_default = 8'h01;
      default: reg_default = 8'h02;
    endcase
  endfunction

  // Bits kept on a write, by index within the bank.
  function automatic logic [REG_W-1:0] reg_mask(input int idx);
    case (idx % RULE_REGS)
      0:       reg_mask = (idx == 0) ? 8'h8F : 8'h0F;
      1:       reg_mask = 8'h87;
      default: reg_mask = 8'h1F;
    endcase
  endfunction

  function automatic rule_t unpack_rule(input logic [REG_W-1:0] r_mon,
                                        input logic [REG_W-1:0] r_dow,
                                        input logic [REG_W-1:0] r_date,
                                        input logic [REG_W-1:0] r_hour);
    rule_t r;
    r.mon      = r_mon[MON_W-1:0];
    r.dow_prio = r_dow[PRIO_BIT];
    r.dow      = r_dow[DOW_W-1:0];
    r.date     = r_date[DATE_W-1:0];
    r.hour     = r_hour[HOUR_W-1:0];
    return r;
  endfunction

  function automatic logic day_hit(input rule_t r, input cal_t c);
    return r.dow_prio ? (c.dow == r.dow) : (c.date == r.date);
  endfunction

  function automatic logic top_of_hour(input cal_t c);
    return (c.min == '0) && (c.sec == '0);
  endfunction
endpackage

// File: rtl/dst_rule_bank.sv
module dst_rule_bank
  import dst_pkg::*;
#(
  parameter logic [REG_W-1:0] RULE_BASE = 8'h15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output rule_t            fwd_rule,
  output rule_t            rev_rule,
  output logic             dst_en
);
  logic [N_REGS-1:0][REG_W-1:0] regs;
  logic [REG_W-1:0]             offset;
  logic                         in_range;
  logic [SEL_W-1:0]             sel;

  assign offset   = wr_addr - RULE_BASE;
  assign in_range = (wr_addr >= RULE_BASE) && (offset < REG_W'(N_REGS));
  assign sel      = offset[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= reg_default(i);
    end else if (wr_en && in_range) begin
      for (int i = 0; i < N_REGS; i++)
        if (sel == SEL_W'(i)) regs[i] <= wr_data & reg_mask(i);
    end
  end

  assign fwd_rule = unpack_rule(regs[0], regs[1], regs[2], regs[3]);
  assign rev_rule = unpack_rule(regs[4], regs[5], regs[6], regs[7]);
  assign dst_en   = regs[0][EN_BIT];

  // R2
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && in_range) |=> $stable(regs));
endmodule

// File: rtl/dst_rule_match.sv
module dst_rule_match
  import dst_pkg::*;
(
  input  rule_t rule,
  input  cal_t  cal,
  output logic  hit
);
  logic month_ok;
  logic day_ok;
  logic hour_ok;
  logic zero_ms;

  assign month_ok = (cal.mon == rule.mon);
  assign day_ok   = day_hit(rule, cal);
  assign hour_ok  = (cal.hour == rule.hour);
  assign zero_ms  = top_of_hour(cal);
  assign hit      = month_ok && day_ok && hour_ok && zero_ms;
endmodule

// File: rtl/dst_event_ctl.sv
module dst_event_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fwd_hit,
  input  logic rev_hit,
  output logic fwd_pulse,
  output logic rev_pulse,
  output logic in_dst
);
  logic fwd_arm, rev_arm;
  logic fwd_arm_q, rev_arm_q;
  logic fwd_fire, rev_fire;

  assign fwd_arm  = en && fwd_hit;
  assign rev_arm  = en && rev_hit;
  assign fwd_fire = fwd_arm && !fwd_arm_q;
  assign rev_fire = rev_arm && !rev_arm_q && in_dst && !fwd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_arm_q <= 1'b0;
      rev_arm_q <= 1'b0;
      fwd_pulse <= 1'b0;
      rev_pulse <= 1'b0;
      in_dst    <= 1'b0;
    end else begin
      fwd_arm_q <= fwd_arm;
      rev_arm_q <= rev_arm;
      fwd_pulse <= fwd_fire;
      rev_pulse <= rev_fire;
      if (fwd_fire)      in_dst <= 1'b1;
      else if (rev_fire) in_dst <= 1'b0;
    end
  end

  // R6
  fwd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_pulse |=> !fwd_pulse);
  // R6
  rev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_pulse |=> !rev_pulse);
  // R5
  fwd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_pulse |-> in_dst);
  // R7
  rev_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_pulse |-> ($past(in_dst) && !in_dst));
  // R8
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_pulse && rev_pulse));
  // R3
  gated_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_pulse || rev_pulse) |-> $past(en));
  // R3
  gated_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> $stable(in_dst));
endmodule

// File: rtl/dst_switch.sv
module dst_switch
  import dst_pkg::*;
#(
  parameter logic [7:0] RULE_BASE = 8'h15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic [3:0] cal_month,
  input  logic [2:0] cal_dow,
  input  logic [4:0] cal_date,
  input  logic [4:0] cal_hour,
  input  logic [5:0] cal_min,
  input  logic [5:0] cal_sec,
  output logic       fwd_strobe,
  output logic       rev_strobe,
  output logic       in_dst
);
  cal_t  cal;
  rule_t rules [N_RULES];
  logic  [N_RULES-1:0] hits;
  logic  dst_en;

  assign cal = '{mon: cal_month, dow: cal_dow, date: cal_date,
                 hour: cal_hour, min: cal_min, sec: cal_sec};

  dst_rule_bank #(.RULE_BASE(RULE_BASE)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .fwd_rule (rules[0]),
    .rev_rule (rules[1]),
    .dst_en   (dst_en)
  );

  for (genvar g = 0; g < N_RULES; g++) begin : g_match
    dst_rule_match u_match (
      .rule (rules[g]),
      .cal  (cal),
      .hit  (hits[g])
    );
  end

  dst_event_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (dst_en),
    .fwd_hit   (hits[0]),
    .rev_hit   (hits[1]),
    .fwd_pulse (fwd_strobe),
    .rev_pulse (rev_strobe),
    .in_dst    (in_dst)
  );

  // R9
  minute_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_min != '0 || cal_sec != '0) |-> (hits == '0));
endmodule

// File: tb/dst_switch_test.sv
module dst_switch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] cal_month = 4'd1;
  logic [2:0] cal_dow = '0;
  logic [4:0] cal_date = 5'd1;
  logic [4:0] cal_hour = '0;
  logic [5:0] cal_min = '0;
  logic [5:0] cal_sec = '0;
  logic       fwd_strobe, rev_strobe, in_dst;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dst_switch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cal_month(cal_month), .cal_dow(cal_dow),
    .cal_date(cal_date), .cal_hour(cal_hour), .cal_min(cal_min),
    .cal_sec(cal_sec), .fwd_strobe(fwd_strobe), .rev_strobe(rev_strobe),
    .in_dst(in_dst)
  );

  // month, dow, date, hour, min, sec, expected {fwd, rev, in_dst}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {4'd3,  3'd0, 5'd10, 5'd1, 6'd0, 6'd0, 3'b000},
    {4'd3,  3'd0, 5'd10, 5'd2, 6'd0, 6'd0, 3'b101},
    {4'd3,  3'd0, 5'd10, 5'd2, 6'd0, 6'd0, 3'b001},
    {4'd3,  3'd0, 5'd10, 5'd3, 6'd0, 6'd0, 3'b001},
    {4'd3,  3'd1, 5'd11, 5'd2, 6'd0, 6'd0, 3'b001},
    {4'd3,  3'd0, 5'd17, 5'd2, 6'd0, 6'd1, 3'b001},
    {4'd3,  3'd0, 5'd17, 5'd2, 6'd1, 6'd0, 3'b001},
    {4'd3,  3'd0, 5'd17, 5'd2, 6'd0, 6'd0, 3'b101},
    {4'd11, 3'd3, 5'd5,  5'd2, 6'd0, 6'd0, 3'b010},
    {4'd11, 3'd3, 5'd5,  5'd1, 6'd0, 6'd0, 3'b000},
    {4'd11, 3'd3, 5'd5,  5'd2, 6'd0, 6'd0, 3'b000},
    {4'd11, 3'd0, 5'd6,  5'd2, 6'd0, 6'd0, 3'b000}
  };
  localparam string VTAG [NV] = '{
    "R9", "R5 R2", "R6", "R4", "R4", "R9", "R9", "R6",
    "R7 R2", "R7", "R7", "R4"
  };

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {fwd,rev,in_dst} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cal(input int m, input int w, input int dt, input int h);
    cal_month = 4'(m); cal_dow = 3'(w); cal_date = 5'(dt); cal_hour = 5'(h);
    cal_min = '0; cal_sec = '0;
  endtask

  function automatic logic [2:0] outs();
    return {fwd_strobe, rev_strobe, in_dst};
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, with the default forward calendar point present
    cal(4, 0, 1, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset", outs(), 3'b000);
    tick();
    chk("R3 disabled default", outs(), 3'b000);
    tick();
    chk("R3 disabled held", outs(), 3'b000);

    // R1: defaults active once enabled (only the enable bit changes)
    cal(4, 0, 1, 1);
    wr(8'h15, 8'h84);
    cal(4, 0, 1, 2);
    tick();
    chk("R1 default fwd rule", outs(), 3'b101);
    cal(4, 0, 1, 1);
    tick();
    cal(10, 5, 1, 2);
    tick();
    chk("R1 default rev rule", outs(), 3'b010);
    cal(10, 5, 1, 1);
    tick();

    // R2: write outside the window must not alter the rules
    wr(8'h14, 8'h00);
    wr(8'h1D, 8'h09);
    cal(4, 0, 1, 2);
    tick();
    chk("R2 stray writes ignored", outs(), 3'b101);
    cal(4, 0, 1, 1);
    tick();

    // R8: both rules match together while the flag is set
    wr(8'h19, 8'h04);
    cal(4, 0, 1, 2);
    tick();
    chk("R8 forward wins", outs(), 3'b101);
    cal(4, 0, 1, 1);
    tick();

    // R3: disable, then a reverse match must do nothing
    wr(8'h15, 8'h04);
    wr(8'h19, 8'h8A);
    cal(10, 0, 1, 2);
    tick();
    chk("R3 rev blocked", outs(), 3'b001);
    tick();
    chk("R3 flag kept", outs(), 3'b001);
    // R2: bit 7 of the reverse month is not an enable and month still decodes
    cal(10, 0, 1, 1);
    tick();
    wr(8'h15, 8'h04 | 8'h80);
    cal(10, 0, 1, 2);
    tick();
    chk("R2 rev month masked", outs(), 3'b010);
    cal(10, 0, 1, 1);
    tick();

    // Table: program rules, then walk the vectors
    wr(8'h15, 8'h83);
    wr(8'h16, 8'h80);
    wr(8'h17, 8'h1F);
    wr(8'h18, 8'h02);
    wr(8'h19, 8'h0B);
    wr(8'h1A, 8'h03);
    wr(8'h1B, 8'h05);
    wr(8'h1C, 8'h02);
    for (int i = 0; i < NV; i++) begin
      {cal_month, cal_dow, cal_date, cal_hour, cal_min, cal_sec} = VEC[i][31:3];
      tick();
      chk(VTAG[i], outs(), VEC[i][2:0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule